// File: doc/BRIEF.md
# Byte-Lane RAM with Selectable Collision Read Policy

A single-clock true dual-port memory. Ports A and B each carry an address, a write enable, a read enable, a per-byte lane-enable mask and write data, and each returns read data. A write changes only the bytes whose lane-enable bit is set, so a later read returns the new bytes merged with the bytes already stored.

When a read and a write reach the same word in the same cycle, the result depends on two elaboration-time settings. One setting covers the case where both operations arrive on the same port. The other covers the case where the write arrives on the opposite port. The result can be the stored word from before the write, the merged word being written, or an undefined value.

An optional output register adds one cycle of read latency. The collision policy is applied before that register. The new-data policy on opposite-port collisions requires the output register. Elaboration rejects that policy without the register, and it also rejects an undefined policy for same-port collisions.

Top module: `bytelane_ram`

## Requirements
- R1: After reset both read-data outputs are zero and stay zero until the first read on that port.
- R2: A write updates only the bytes whose lane-enable bit is set. Lane i is data bits [8i+7:8i] and is controlled by lane-enable bit i. A later read returns the newly written lanes together with the untouched old lanes.
- R3: A write with write enable high and an all-zero lane-enable mask leaves the stored word unchanged.
- R4: A read presents the word at its address after the clock edge that samples it. With the output register, the word appears one edge later.
- R5: While a port's read enable is low, that port's read data holds its previous value.
- R6: With the same-port old setting, a port that reads and writes one address in one cycle returns the contents from before the write.
- R7: With the same-port new setting, that port returns the merged word: the written bytes in the enabled lanes and the old bytes in the other lanes.
- R8: With the opposite-port old setting, a read that collides with a write from the other port returns the word stored before the write.
- R9: With the opposite-port new setting, such a read returns the merged word: the other port's enabled lanes and the old bytes elsewhere.
- R10: With the opposite-port undefined setting, such a read yields an undefined value. A read is treated as a collision only when the addresses are equal, so a read at a different address is unaffected.
- R11: When both ports write the same address in one cycle, port B's data wins in every lane that both ports enable, and each port's other enabled lanes are written normally.
- R12: Both ports operate at the same time: in one cycle each port can read or write its own address independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every operation |
| rstN | input | 1 | Active-low synchronous reset of the read registers |
| aAddr | input | ADDR_W | Port A word address |
| aWrEn | input | 1 | Port A write enable |
| aRdEn | input | 1 | Port A read enable |
| aByteEn | input | LANES | Port A lane-enable mask |
| aWrData | input | DATA_W | Port A write data |
| aRdData | output | DATA_W | Port A read data |
| bAddr | input | ADDR_W | Port B word address |
| bWrEn | input | 1 | Port B write enable |
| bRdEn | input | 1 | Port B read enable |
| bByteEn | input | LANES | Port B lane-enable mask |
| bWrData | input | DATA_W | Port B write data |
| bRdData | output | DATA_W | Port B read data |

## Verification
The assertions are checked on every cycle. They cover the hold of read data while read enable is low, full-word readback after the configured latency, the old-data result of opposite-port collisions, the lane-wise new-data result of opposite-port collisions, and the rule that a collision is flagged only for equal addresses and non-empty masks.

The bench runs one stimulus through three configurations and compares every read against a behavioural model. That comparison is the only evidence for the partial-lane merge, same-port write-through, the write race on a shared address and simultaneous operation of both ports. Cycles that end in the undefined policy are left unchecked, and so is any later hold of such a value.

// File: rtl/bytelane_ram_pkg.sv
package bytelane_ram_pkg;

  // Read result when a read meets a write to the same word
  typedef enum logic [1:0] {
    RDW_OLD      = 2'd0,
    RDW_NEW      = 2'd1,
    RDW_DONTCARE = 2'd2
  } rdw_e;

  // Strobes from control to datapath; index 0 is port A, 1 is port B
  typedef struct packed {
    logic [1:0]      wrGo;  // write that touches at least one lane
    logic [1:0]      rdGo;  // read capture
    logic [1:0][1:0] hit;   // hit[r][w]: read on r meets write on w, same word
  } ram_strb_t;

endpackage

// File: rtl/bytelane_ram_ctrl.sv
module bytelane_ram_ctrl
  import bytelane_ram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic [1:0][ADDR_W-1:0] addr,
  input  logic [1:0]             wrEn,
  input  logic [1:0]             rdEn,
  input  logic [1:0][LANES-1:0]  byteEn,
  output ram_strb_t              strb
);

  localparam int PORTS = 2;

  always_comb begin
    strb = '0;
    for (int w = 0; w < PORTS; w++) begin
      strb.wrGo[w] = wrEn[w] & (|byteEn[w]);
      strb.rdGo[w] = rdEn[w];
    end
    for (int r = 0; r < PORTS; r++) begin
      for (int w = 0; w < PORTS; w++) begin
        strb.hit[r][w] = rdEn[r] & strb.wrGo[w] & (addr[r] == addr[w]);
      end
    end
  end

endmodule

// File: rtl/bytelane_ram_dp.sv
module bytelane_ram_dp
  import bytelane_ram_pkg::*;
#(
  parameter int   DATA_W    = 32,
  parameter int   LANE_W    = 8,
  parameter int   DEPTH     = 64,
  parameter rdw_e MIXED_RDW = RDW_OLD,
  parameter rdw_e SAME_RDW  = RDW_OLD,
  parameter bit   OUT_REG   = 1'b1,
  localparam int  LANES     = DATA_W / LANE_W,
  localparam int  ADDR_W    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ram_strb_t              strb,
  input  logic [1:0][ADDR_W-1:0] addr,
  input  logic [1:0][LANES-1:0]  byteEn,
  input  logic [1:0][DATA_W-1:0] wrData,
  output logic [1:0][DATA_W-1:0] rdData
);

  localparam int PORTS = 2;

  logic [DATA_W-1:0] store [DEPTH];

  function automatic logic [DATA_W-1:0] mergeLanes(
    input logic [DATA_W-1:0] base,
    input logic [DATA_W-1:0] fresh,
    input logic [LANES-1:0]  mask
  );
    logic [DATA_W-1:0] res;
    res = base;
    for (int l = 0; l < LANES; l++) begin
      if (mask[l]) res[l*LANE_W +: LANE_W] = fresh[l*LANE_W +: LANE_W];
    end
    return res;
  endfunction

  // Port A is applied first, so port B wins a shared lane
  always_ff @(posedge clk) begin
    for (int w = 0; w < PORTS; w++) begin
      if (strb.wrGo[w]) begin
        for (int l = 0; l < LANES; l++) begin
          if (byteEn[w][l]) begin
            store[addr[w]][l*LANE_W +: LANE_W] <= wrData[w][l*LANE_W +: LANE_W];
          end
        end
      end
    end
  end

  for (genvar r = 0; r < PORTS; r++) begin : g_rd
    logic [DATA_W-1:0] view;
    logic [DATA_W-1:0] capReg;

    // Collision policy, applied in the same order as the writes land
    always_comb begin
      rdw_e mode;
      view = store[addr[r]];
      for (int w = 0; w < PORTS; w++) begin
        mode = (w == r) ? SAME_RDW : MIXED_RDW;
        if (strb.hit[r][w]) begin
          if (mode == RDW_NEW)           view = mergeLanes(view, wrData[w], byteEn[w]);
          else if (mode == RDW_DONTCARE) view = 'x;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN)              capReg <= '0;
      else if (strb.rdGo[r])  capReg <= view;
    end

    if (OUT_REG) begin : g_oreg
      logic [DATA_W-1:0] outReg;
      always_ff @(posedge clk) begin
        if (!rstN) outReg <= '0;
        else       outReg <= capReg;
      end
      assign rdData[r] = outReg;
    end else begin : g_nreg
      assign rdData[r] = capReg;
    end
  end

endmodule

// File: rtl/bytelane_ram.sv
module bytelane_ram
  import bytelane_ram_pkg::*;
#(
  parameter int   DATA_W    = 32,
  parameter int   LANE_W    = 8,
  parameter int   DEPTH     = 64,
  parameter rdw_e MIXED_RDW = RDW_OLD,
  parameter rdw_e SAME_RDW  = RDW_OLD,
  parameter bit   OUT_REG   = 1'b1,
  localparam int  LANES     = DATA_W / LANE_W,
  localparam int  ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic              aWrEn,
  input  logic              aRdEn,
  input  logic [LANES-1:0]  aByteEn,
  input  logic [DATA_W-1:0] aWrData,
  output logic [DATA_W-1:0] aRdData,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic              bWrEn,
  input  logic              bRdEn,
  input  logic [LANES-1:0]  bByteEn,
  input  logic [DATA_W-1:0] bWrData,
  output logic [DATA_W-1:0] bRdData
);

  if (SAME_RDW == RDW_DONTCARE || (MIXED_RDW == RDW_NEW && !OUT_REG)) begin : g_badCfg
    $error("bytelane_ram: illegal read-during-write configuration");
  end

  ram_strb_t               strb;
  logic [1:0][ADDR_W-1:0]  addrV;
  logic [1:0]              wrEnV;
  logic [1:0]              rdEnV;
  logic [1:0][LANES-1:0]   beV;
  logic [1:0][DATA_W-1:0]  wdV;
  logic [1:0][DATA_W-1:0]  rdV;

  assign addrV[0] = aAddr;   assign addrV[1] = bAddr;
  assign wrEnV[0] = aWrEn;   assign wrEnV[1] = bWrEn;
  assign rdEnV[0] = aRdEn;   assign rdEnV[1] = bRdEn;
  assign beV[0]   = aByteEn; assign beV[1]   = bByteEn;
  assign wdV[0]   = aWrData; assign wdV[1]   = bWrData;
  assign aRdData  = rdV[0];
  assign bRdData  = rdV[1];

  bytelane_ram_ctrl #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
  ) u_ctrl (
    .addr   (addrV),
    .wrEn   (wrEnV),
    .rdEn   (rdEnV),
    .byteEn (beV),
    .strb   (strb)
  );

  bytelane_ram_dp #(
    .DATA_W    (DATA_W),
    .LANE_W    (LANE_W),
    .DEPTH     (DEPTH),
    .MIXED_RDW (MIXED_RDW),
    .SAME_RDW  (SAME_RDW),
    .OUT_REG   (OUT_REG)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .addr   (addrV),
    .byteEn (beV),
    .wrData (wdV),
    .rdData (rdV)
  );

endmodule

// File: rtl/bytelane_ram_chk.sv
module bytelane_ram_chk
  import bytelane_ram_pkg::*;
#(
  parameter int   DATA_W    = 32,
  parameter int   LANE_W    = 8,
  parameter int   ADDR_W    = 6,
  parameter rdw_e MIXED_RDW = RDW_OLD,
  parameter bit   OUT_REG   = 1'b1,
  localparam int  LANES     = DATA_W / LANE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] aAddr,
  input logic              aWrEn,
  input logic              aRdEn,
  input logic [LANES-1:0]  aByteEn,
  input logic [ADDR_W-1:0] bAddr,
  input logic              bWrEn,
  input logic              bRdEn,
  input logic [LANES-1:0]  bByteEn,
  input logic [DATA_W-1:0] bWrData,
  input logic [DATA_W-1:0] aRdData,
  input logic [DATA_W-1:0] bRdData,
  input ram_strb_t         strb
);

  logic              aIdlePrev, bIdlePrev;
  logic              bFullPrev;
  logic [ADDR_W-1:0] bAddrPrev;
  logic [DATA_W-1:0] bDataPrev;
  logic              aPlainPrev;
  logic [ADDR_W-1:0] aAddrPrev;
  logic              aNoWrHere;
  logic              bWrHitsA;

  assign aNoWrHere = !(aWrEn && |aByteEn) && !(bWrEn && |bByteEn && bAddr == aAddr);
  assign bWrHitsA  = bWrEn && |bByteEn && bAddr == aAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aIdlePrev  <= 1'b1;
      bIdlePrev  <= 1'b1;
      bFullPrev  <= 1'b0;
      bAddrPrev  <= '0;
      bDataPrev  <= '0;
      aPlainPrev <= 1'b0;
      aAddrPrev  <= '0;
    end else begin
      aIdlePrev  <= !aRdEn;
      bIdlePrev  <= !bRdEn;
      bFullPrev  <= bWrEn && (&bByteEn);
      bAddrPrev  <= bAddr;
      bDataPrev  <= bWrData;
      aPlainPrev <= aRdEn && aNoWrHere;
      aAddrPrev  <= aAddr;
    end
  end

  // R10: a collision is never flagged for unequal addresses
  a_r10_no_hit_diff_addr: assert property (@(posedge clk) disable iff (!rstN)
    (aAddr != bAddr) |-> (strb.hit[0][1] == 1'b0 && strb.hit[1][0] == 1'b0));

  // R3: an empty lane mask never becomes a write
  a_r3_empty_mask_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (aByteEn == '0 || bByteEn == '0) |->
      !((aByteEn == '0 && strb.wrGo[0]) || (bByteEn == '0 && strb.wrGo[1])));

  if (OUT_REG) begin : g_lat2
    // R5: idle read port holds its data
    a_r5_hold_a: assert property (@(posedge clk) disable iff (!rstN)
      (!aRdEn && aIdlePrev) |=> $stable(aRdData));
    a_r5_hold_b: assert property (@(posedge clk) disable iff (!rstN)
      (!bRdEn && bIdlePrev) |=> $stable(bRdData));
    // R4: full word written by B is read back by A after two edges
    a_r4_readback_latency: assert property (@(posedge clk) disable iff (!rstN)
      (aRdEn && aNoWrHere && bFullPrev && bAddrPrev == aAddr) |=> ##1
        (aRdData == $past(bDataPrev, 2)));
    if (MIXED_RDW == RDW_OLD) begin : g_old
      // R8: colliding read equals the preceding plain read of that word
      a_r8_mixed_old: assert property (@(posedge clk) disable iff (!rstN)
        (aPlainPrev && aAddrPrev == aAddr && aRdEn && !(aWrEn && |aByteEn) && bWrHitsA)
          |=> ##1 $stable(aRdData));
    end
    if (MIXED_RDW == RDW_NEW) begin : g_new
      for (genvar l = 0; l < LANES; l++) begin : g_lane
        // R9: enabled lanes of the opposite write show up in the read
        a_r9_mixed_new_lane: assert property (@(posedge clk) disable iff (!rstN)
          (aRdEn && bWrEn && bByteEn[l] && bAddr == aAddr) |=> ##1
            (aRdData[l*LANE_W +: LANE_W] == $past(bWrData[l*LANE_W +: LANE_W], 2)));
      end
    end
  end else begin : g_lat1
    a_r5_hold_a: assert property (@(posedge clk) disable iff (!rstN)
      !aRdEn |=> $stable(aRdData));
    a_r5_hold_b: assert property (@(posedge clk) disable iff (!rstN)
      !bRdEn |=> $stable(bRdData));
    a_r4_readback_latency: assert property (@(posedge clk) disable iff (!rstN)
      (aRdEn && aNoWrHere && bFullPrev && bAddrPrev == aAddr) |=>
        (aRdData == $past(bDataPrev)));
    if (MIXED_RDW == RDW_OLD) begin : g_old
      a_r8_mixed_old: assert property (@(posedge clk) disable iff (!rstN)
        (aPlainPrev && aAddrPrev == aAddr && aRdEn && !(aWrEn && |aByteEn) && bWrHitsA)
          |=> $stable(aRdData));
    end
  end

endmodule

bind bytelane_ram bytelane_ram_chk #(
  .DATA_W    (DATA_W),
  .LANE_W    (LANE_W),
  .ADDR_W    (ADDR_W),
  .MIXED_RDW (MIXED_RDW),
  .OUT_REG   (OUT_REG)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .aAddr   (aAddr),
  .aWrEn   (aWrEn),
  .aRdEn   (aRdEn),
  .aByteEn (aByteEn),
  .bAddr   (bAddr),
  .bWrEn   (bWrEn),
  .bRdEn   (bRdEn),
  .bByteEn (bByteEn),
  .bWrData (bWrData),
  .aRdData (aRdData),
  .bRdData (bRdData),
  .strb    (strb)
);

// File: tb/bytelane_ram_bench.sv
`timescale 1ns/1ps
module bytelane_ram_bench;
  import bytelane_ram_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]  wen, ren;
  logic [5:0]  adr [2];
  logic [3:0]  be  [2];
  logic [31:0] wd  [2];
  logic [31:0] outA [3];
  logic [31:0] outB [3];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  string curTag = "";

  // Configurations: 0 old/old reg, 1 new/new reg, 2 dontcare/old no reg
  int   cfgOut  [3] = '{1, 1, 0};
  rdw_e cfgMix  [3] = '{RDW_OLD, RDW_NEW, RDW_DONTCARE};
  rdw_e cfgSame [3] = '{RDW_OLD, RDW_NEW, RDW_OLD};

  logic [31:0] refMem [64];
  logic [31:0] s1v [3][2];
  logic [31:0] s2v [3][2];
  bit          s1k [3][2];
  bit          s2k [3][2];
  string       s1t [3][2];
  string       s2t [3][2];

  bytelane_ram #(.MIXED_RDW(RDW_OLD), .SAME_RDW(RDW_OLD), .OUT_REG(1'b1)) u_bytelane_ram (
    .clk(clk), .rstN(rstN),
    .aAddr(adr[0]), .aWrEn(wen[0]), .aRdEn(ren[0]), .aByteEn(be[0]), .aWrData(wd[0]), .aRdData(outA[0]),
    .bAddr(adr[1]), .bWrEn(wen[1]), .bRdEn(ren[1]), .bByteEn(be[1]), .bWrData(wd[1]), .bRdData(outB[0]));

  bytelane_ram #(.MIXED_RDW(RDW_NEW), .SAME_RDW(RDW_NEW), .OUT_REG(1'b1)) u_bytelane_ram_wt (
    .clk(clk), .rstN(rstN),
    .aAddr(adr[0]), .aWrEn(wen[0]), .aRdEn(ren[0]), .aByteEn(be[0]), .aWrData(wd[0]), .aRdData(outA[1]),
    .bAddr(adr[1]), .bWrEn(wen[1]), .bRdEn(ren[1]), .bByteEn(be[1]), .bWrData(wd[1]), .bRdData(outB[1]));

  bytelane_ram #(.MIXED_RDW(RDW_DONTCARE), .SAME_RDW(RDW_OLD), .OUT_REG(1'b0)) u_bytelane_ram_dc (
    .clk(clk), .rstN(rstN),
    .aAddr(adr[0]), .aWrEn(wen[0]), .aRdEn(ren[0]), .aByteEn(be[0]), .aWrData(wd[0]), .aRdData(outA[2]),
    .bAddr(adr[1]), .bWrEn(wen[1]), .bRdEn(ren[1]), .bByteEn(be[1]), .bWrData(wd[1]), .bRdData(outB[2]));

  function automatic logic [31:0] mix(input logic [31:0] o, input logic [31:0] n, input logic [3:0] m);
    logic [31:0] r = o;
    for (int l = 0; l < 4; l++) if (m[l]) r[l*8 +: 8] = n[l*8 +: 8];
    return r;
  endfunction

  task automatic idle();
    wen = '0; ren = '0;
    for (int p = 0; p < 2; p++) begin adr[p] = '0; be[p] = '0; wd[p] = '0; end
  endtask

  task automatic compareAll();
    for (int c = 0; c < 3; c++) begin
      for (int r = 0; r < 2; r++) begin
        logic [31:0] got = (r == 0) ? outA[c] : outB[c];
        logic [31:0] ex  = cfgOut[c] ? s2v[c][r] : s1v[c][r];
        bit          kn  = cfgOut[c] ? s2k[c][r] : s1k[c][r];
        string       tg  = cfgOut[c] ? s2t[c][r] : s1t[c][r];
        if (kn) begin
          checks++;
          if (got !== ex) begin
            errors++;
            $display("FAIL %s cfg%0d port%0d actual %h expected %h", tg, c, r, got, ex);
          end
        end
      end
    end
  endtask

  task automatic tick();
    for (int c = 0; c < 3; c++) begin
      for (int r = 0; r < 2; r++) begin
        s2v[c][r] = s1v[c][r]; s2k[c][r] = s1k[c][r]; s2t[c][r] = s1t[c][r];
        if (ren[r]) begin
          logic [31:0] v = refMem[adr[r]];
          bit k = 1'b1;
          string t = (curTag != "") ? curTag : "R4";
          for (int w = 0; w < 2; w++) begin
            if (wen[w] && be[w] != 0 && adr[w] == adr[r]) begin
              rdw_e m = (w == r) ? cfgSame[c] : cfgMix[c];
              if (w == r) t = (m == RDW_NEW) ? "R7" : "R6";
              else        t = (m == RDW_OLD) ? "R8" : (m == RDW_NEW) ? "R9" : "R10";
              if (m == RDW_NEW) v = mix(v, wd[w], be[w]);
              else if (m == RDW_DONTCARE) k = 1'b0;
            end
          end
          s1v[c][r] = v; s1k[c][r] = k; s1t[c][r] = t;
        end else begin
          s1t[c][r] = "R5";
        end
      end
    end
    for (int w = 0; w < 2; w++)
      if (wen[w]) refMem[adr[w]] = mix(refMem[adr[w]], wd[w], be[w]);
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 3; c++)
      for (int r = 0; r < 2; r++) begin
        s1v[c][r] = '0; s2v[c][r] = '0; s1k[c][r] = 1'b1; s2k[c][r] = 1'b1;
        s1t[c][r] = "R1"; s2t[c][r] = "R1";
      end
    idle();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll();                                   // R1 reset value

    for (int i = 0; i < 64; i++) begin              // prime every word
      idle(); wen[0] = 1'b1; be[0] = 4'hF; adr[0] = 6'(i);
      wd[0] = 32'hA500_0000 ^ (i * 32'h0101_0101);
      tick();
    end
    idle(); tick();

    curTag = "R4";                                  // plain reads and latency
    idle(); ren = 2'b11; adr[0] = 6'd5; adr[1] = 6'd9; tick();
    idle(); tick(); tick();                         // R5 hold
    idle(); wen[1] = 1'b1; be[1] = 4'hF; adr[1] = 6'd20; wd[1] = 32'h1357_9BDF; tick();
    idle(); ren[0] = 1'b1; adr[0] = 6'd20; tick();
    idle(); tick(); tick();

    curTag = "R2";                                  // partial lanes
    idle(); wen[0] = 1'b1; be[0] = 4'b0101; adr[0] = 6'd10; wd[0] = 32'hDEAD_BEEF; tick();
    idle(); ren = 2'b11; adr[0] = 6'd10; adr[1] = 6'd10; tick();
    idle(); tick(); tick();

    curTag = "R3";                                  // empty mask
    idle(); wen[0] = 1'b1; be[0] = 4'b0000; adr[0] = 6'd11; wd[0] = 32'hFFFF_FFFF; tick();
    idle(); ren[0] = 1'b1; adr[0] = 6'd11; tick();
    idle(); tick(); tick();

    curTag = "";                                    // same-port R6 / R7
    idle(); wen[0] = 1'b1; ren[0] = 1'b1; be[0] = 4'b0011; adr[0] = 6'd12; wd[0] = 32'h1122_3344; tick();
    idle(); ren[1] = 1'b1; wen[1] = 1'b1; be[1] = 4'b1000; adr[1] = 6'd13; wd[1] = 32'h9900_0000; tick();
    idle(); tick(); tick();

    // opposite-port collisions R8 / R9 / R10
    idle(); ren[0] = 1'b1; adr[0] = 6'd14; wen[1] = 1'b1; be[1] = 4'b1010; adr[1] = 6'd14; wd[1] = 32'hCAFE_F00D; tick();
    idle(); ren[1] = 1'b1; adr[1] = 6'd15; wen[0] = 1'b1; be[0] = 4'hF; adr[0] = 6'd15; wd[0] = 32'h0BAD_C0DE; tick();
    idle(); ren = 2'b11; adr[0] = 6'd14; adr[1] = 6'd15; tick();
    idle(); tick(); tick();

    curTag = "R10";                                 // different address, no collision
    idle(); ren[0] = 1'b1; adr[0] = 6'd16; wen[1] = 1'b1; be[1] = 4'hF; adr[1] = 6'd17; wd[1] = 32'h7777_0000; tick();
    idle(); tick(); tick();

    curTag = "R11";                                 // write race on one word
    idle(); wen = 2'b11; adr[0] = 6'd18; adr[1] = 6'd18; be[0] = 4'hF; be[1] = 4'b0110;
    wd[0] = 32'h1111_1111; wd[1] = 32'h2222_2222; tick();
    idle(); ren = 2'b11; adr[0] = 6'd18; adr[1] = 6'd18; tick();
    idle(); tick(); tick();

    curTag = "R12";                                 // both ports busy, distinct words
    idle(); wen[0] = 1'b1; ren[1] = 1'b1; adr[0] = 6'd21; adr[1] = 6'd22; be[0] = 4'hF; wd[0] = 32'h4444_5555; tick();
    idle(); wen[1] = 1'b1; ren[0] = 1'b1; adr[1] = 6'd23; adr[0] = 6'd21; be[1] = 4'hF; wd[1] = 32'h6666_7777; tick();
    idle(); ren = 2'b11; adr[0] = 6'd23; adr[1] = 6'd21; tick();
    idle(); tick(); tick();

    curTag = "";                                    // mixed traffic on few words
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < 2; p++) begin
        wen[p] = 1'($urandom); ren[p] = 1'($urandom);
        adr[p] = 6'($urandom % 4); be[p] = 4'($urandom); wd[p] = $urandom;
      end
      tick();
    end
    idle(); tick(); tick();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule